// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Bypassable Prescaler

This block is an 8-bit up-counter that software can load at any time. It counts either an internal tick that fires once per instruction cycle or rising edges on an external pin. The external edges are first brought into the system-clock domain by two samples taken at fixed points of the instruction cycle. A programmable divider sits between the selected source and the counter, and one control bit skips it. The divider ratio is a power of two between 2 and 256. The divider is hidden from software, and any load of the count resets it.

When the count wraps from all ones to zero, a sticky flag is set. The flag stays set until software pulses a clear strobe. The interrupt line is that flag masked by an enable input. A sleep input freezes the count and the divider, so the timer cannot raise an event while the system sleeps.

The instruction cycle is four system clocks long. A free-running two-bit phase counter marks it, and that counter starts from zero at reset.

Top module: `tick_timer8`

## Requirements
- R1: While reset is asserted, and directly after it is released, `cnt_q` is 8'h00 and `ovf_flag` and `irq` are 0.
- R2: With `src_ext`=0 and `ps_bypass`=1, the count advances by one on the clock edge that ends each fourth system-clock cycle after reset, which is the last phase of the instruction cycle. That is one step per instruction cycle.
- R3: With `ps_bypass`=0, the count advances once per 2^(`ps_sel`+1) source ticks: `ps_sel`=3'b000 gives 1:2 and `ps_sel`=3'b111 gives 1:256. The divider is counted from its cleared state.
- R4: A cycle with `cnt_wr_en`=1 loads `cnt_wr_data` into the count at the next edge and resets the hidden divider to zero.
- R5: A wrap of the count from 8'hFF to 8'h00 sets `ovf_flag`, whatever the value of `irq_en`.
- R6: `ovf_flag` stays set through further counting and count writes. Only `flag_clr`=1 clears it. If a clear and a wrap happen in the same cycle, the flag stays set.
- R7: `irq` is 1 exactly when `ovf_flag`=1 and `irq_en`=1.
- R8: If a count write and an increment fall on the same edge, the written value is loaded and the flag does not set from that edge.
- R9: With `src_ext`=1, each rising edge of `ext_in` advances the divider at most once. `ext_in` is sampled when the phase is 1 and again when it is 3, and it must stay at one level for at least two instruction cycles between edges. Internal ticks are ignored in this mode.
- R10: While `sleep`=1, the count and the divider hold their values and the flag cannot set. Counting resumes from the held state when `sleep` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr_en | input | 1 | Count write strobe |
| cnt_wr_data | input | 8 | Value to load into the count |
| ps_bypass | input | 1 | 1 skips the divider (1:1) |
| ps_sel | input | 3 | Divider ratio select, ratio 2^(sel+1) |
| src_ext | input | 1 | 0 internal tick, 1 external pin |
| ext_in | input | 1 | External count input (asynchronous) |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Software clear strobe for the flag |
| sleep | input | 1 | Freeze counting while high |
| cnt_q | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky wrap flag |
| irq | output | 1 | Flag masked by the enable |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 3-bit ratio select and a 2-bit phase counter. With these values the coarsest ratio, 1:256, completes within a few hundred instruction cycles, so a wrap can be reached from 8'hFF after one divided step. The four-clock instruction cycle lets the bench place a write or a flag clear exactly on the phase-3 edge where an increment lands. The bench also gives the divider a partial count and then shows that a write or a sleep period changes what happens next.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } tmr8_src_e;

    // Number of divider bits that must be all ones for a carry.
    function automatic int carry_bits(input int sel);
        return sel + 1;
    endfunction

endpackage

// File: rtl/tmr8_phase.sv
module tmr8_phase #(
    parameter int PH_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_int,
    output logic samp_a,
    output logic samp_b
);
    localparam int NPH    = 1 << PH_W;
    localparam int PH_A   = NPH / 2 - 1;
    localparam int PH_B   = NPH - 1;

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = st_q.ph + PH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_int = (st_q.ph == PH_W'(PH_B));
    assign samp_a   = (st_q.ph == PH_W'(PH_A));
    assign samp_b   = (st_q.ph == PH_W'(PH_B));

    // R2: the phase walks forward by one every clock
    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.ph == $past(st_q.ph) + PH_W'(1));

endmodule

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic samp_a,
    input  logic samp_b,
    output logic ext_tick
);
    typedef struct packed {
        logic a;   // first sample, taken on phase A
        logic b;   // second sample, taken on phase B
    } sy_st_t;

    sy_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (samp_a) st_d.a = ext_in;
        if (samp_b) st_d.b = st_q.a;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A rising edge is a new high sample against the previous one.
    assign ext_tick = samp_b && st_q.a && !st_q.b;

    // R9: one edge yields a single tick, never two in a row
    a_r9_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |=> !ext_tick);

    // R9: after a tick the second stage holds the high level
    a_r9_stage_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |=> st_q.b);

endmodule

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
    import tmr8_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             bypass,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr,
    input  logic             hold,
    output logic             inc_out
);
    localparam int PS_W = 1 << SEL_W;

    typedef struct packed {
        logic [PS_W-1:0] pre;
    } ps_st_t;

    ps_st_t          st_d, st_q;
    logic [PS_W-1:0] mask;
    logic            carry;

    always_comb begin
        for (int i = 0; i < PS_W; i++) begin
            mask[i] = (i < carry_bits(int'(sel)));
        end
    end

    assign carry = ((st_q.pre & mask) == mask);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.pre = '0;
        end else if (tick_in && !bypass && !hold) begin
            st_d.pre = st_q.pre + PS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (hold)        inc_out = 1'b0;
        else if (bypass) inc_out = tick_in;
        else             inc_out = tick_in && carry;
    end

    // R4: a count write leaves the divider at zero
    a_r4_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.pre == '0);

    // R10: sleep without a write keeps the divider where it was
    a_r10_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !clr |=> st_q.pre == $past(st_q.pre));

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             sleep,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     wrap;

    always_comb begin
        st_d = st_q;
        wrap = inc && !sleep && !wr_en && (st_q.cnt == '1);
        if (wr_en) begin
            st_d.cnt = wr_data;
        end else if (inc && !sleep) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (wrap) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign flag = st_q.flag;
    assign irq  = st_q.flag && irq_en;

    // R8: a write always determines the next count
    a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.cnt == $past(wr_data));

    // R6: the flag only falls after a clear strobe
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag && !flag_clr |=> st_q.flag);

    // R5: a wrap from all ones raises the flag
    a_r5_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !sleep && !wr_en && st_q.cnt == '1 |=> st_q.flag && st_q.cnt == '0);

    // R10: sleep holds the count and blocks a new flag
    a_r10_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sleep && !wr_en |=> st_q.cnt == $past(st_q.cnt) && !$rose(st_q.flag));

endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3,
    parameter int PH_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             ps_bypass,
    input  logic [SEL_W-1:0] ps_sel,
    input  logic             src_ext,
    input  logic             ext_in,
    input  logic             irq_en,
    input  logic             flag_clr,
    input  logic             sleep,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_flag,
    output logic             irq
);
    logic      tick_int, samp_a, samp_b, ext_tick;
    logic      src_tick, inc;
    tmr8_src_e src_mode;

    assign src_mode = tmr8_src_e'(src_ext);

    tmr8_phase #(.PH_W(PH_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_int (tick_int),
        .samp_a   (samp_a),
        .samp_b   (samp_b)
    );

    tmr8_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_in),
        .samp_a   (samp_a),
        .samp_b   (samp_b),
        .ext_tick (ext_tick)
    );

    always_comb begin
        case (src_mode)
            SRC_EXT: src_tick = ext_tick;
            default: src_tick = tick_int;
        endcase
    end

    tmr8_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_in (src_tick),
        .bypass  (ps_bypass),
        .sel     (ps_sel),
        .clr     (cnt_wr_en),
        .hold    (sleep),
        .inc_out (inc)
    );

    tmr8_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .wr_en    (cnt_wr_en),
        .wr_data  (cnt_wr_data),
        .sleep    (sleep),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .cnt      (cnt_q),
        .flag     (ovf_flag),
        .irq      (irq)
    );

    // R7: the interrupt never fires while disabled
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

endmodule

// File: tb/tick_timer8_test.sv
`timescale 1ns/1ps
module tick_timer8_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_wr_en = 1'b0;
    logic [7:0] cnt_wr_data = 8'h00;
    logic       ps_bypass = 1'b1;
    logic [2:0] ps_sel = 3'd0;
    logic       src_ext = 1'b0;
    logic       ext_in = 1'b0;
    logic       irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       sleep = 1'b0;
    logic [7:0] cnt_q;
    logic       ovf_flag, irq;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    tick_timer8 uut (
        .clk(clk), .rst_n(rst_n), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .ps_bypass(ps_bypass), .ps_sel(ps_sel), .src_ext(src_ext), .ext_in(ext_in),
        .irq_en(irq_en), .flag_clr(flag_clr), .sleep(sleep),
        .cnt_q(cnt_q), .ovf_flag(ovf_flag), .irq(irq)
    );

    typedef struct packed {
        logic        byp;
        logic [2:0]  sel;
        logic [7:0]  val;
        logic [15:0] ncyc;
        logic [7:0]  exp_cnt;
        logic        exp_flag;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{1'b1, 3'd0, 8'h10, 16'd5,   8'h15, 1'b0},
        '{1'b1, 3'd0, 8'hFE, 16'd3,   8'h01, 1'b1},
        '{1'b0, 3'd0, 8'h20, 16'd7,   8'h23, 1'b0},
        '{1'b0, 3'd2, 8'h00, 16'd20,  8'h02, 1'b0},
        '{1'b0, 3'd7, 8'h05, 16'd600, 8'h07, 1'b0},
        '{1'b0, 3'd1, 8'hFF, 16'd4,   8'h00, 1'b1},
        '{1'b0, 3'd3, 8'hFF, 16'd15,  8'hFF, 1'b0},
        '{1'b0, 3'd7, 8'hFF, 16'd256, 8'h00, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic align_to(input int p);
        @(negedge clk);
        while ((cyc % 4) != p) @(negedge clk);
    endtask

    task automatic write_cnt(input logic [7:0] v, input logic clr);
        align_to(0);
        cnt_wr_en   = 1'b1;
        cnt_wr_data = v;
        flag_clr    = clr;
        @(negedge clk);
        cnt_wr_en = 1'b0;
        flag_clr  = 1'b0;
    endtask

    task automatic run_icyc(input int n);
        repeat (4 * n) @(negedge clk);
    endtask

    task automatic ext_pulse();
        ext_in = 1'b1;
        repeat (8) @(negedge clk);
        ext_in = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic run_all();
        // R1 reset state, during and after reset
        repeat (3) @(negedge clk);
        chk(cnt_q == 8'h00, "R1", "count in reset", cnt_q, 0);
        chk(!ovf_flag && !irq, "R1", "flag/irq in reset", {ovf_flag, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cnt_q == 8'h00 && !ovf_flag, "R1", "state after release", cnt_q, 0);

        // Vector table: R2 bypass rate, R3 ratios, R5 wrap
        for (int k = 0; k < NVEC; k++) begin
            ps_bypass = VEC[k].byp;
            ps_sel    = VEC[k].sel;
            write_cnt(VEC[k].val, 1'b1);
            run_icyc(int'(VEC[k].ncyc));
            chk(cnt_q == VEC[k].exp_cnt, VEC[k].byp ? "R2" : "R3",
                $sformatf("vector %0d count", k), cnt_q, VEC[k].exp_cnt);
            chk(ovf_flag == VEC[k].exp_flag, "R5",
                $sformatf("vector %0d flag", k), ovf_flag, VEC[k].exp_flag);
        end

        // R5/R7: flag sets with interrupt disabled, irq follows enable
        ps_bypass = 1'b1;
        irq_en = 1'b0;
        write_cnt(8'hFE, 1'b1);
        run_icyc(2);
        chk(cnt_q == 8'h00 && ovf_flag, "R5", "wrap with irq disabled", {cnt_q, ovf_flag}, 1);
        chk(!irq, "R7", "irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        chk(irq, "R7", "irq enabled", irq, 1);
        // R6: sticky through counting and a write
        run_icyc(3);
        chk(ovf_flag, "R6", "flag after counting on", ovf_flag, 1);
        write_cnt(8'h80, 1'b0);
        chk(ovf_flag && cnt_q == 8'h80, "R6", "flag after count write", ovf_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(!ovf_flag && !irq, "R6", "flag cleared by strobe", {ovf_flag, irq}, 0);
        irq_en = 1'b0;

        // R4: write clears partially counted divider (1:4)
        ps_bypass = 1'b0;
        ps_sel    = 3'd1;
        write_cnt(8'h30, 1'b1);
        run_icyc(2);              // divider now 2, then 1 more tick during align
        write_cnt(8'h30, 1'b0);
        run_icyc(3);
        chk(cnt_q == 8'h30, "R4", "divider cleared by write", cnt_q, 8'h30);
        run_icyc(1);
        chk(cnt_q == 8'h31, "R4", "step after fourth tick", cnt_q, 8'h31);

        // R10: sleep holds divider
        write_cnt(8'h10, 1'b1);
        run_icyc(2);
        sleep = 1'b1;
        run_icyc(5);
        chk(cnt_q == 8'h10, "R10", "count held in sleep", cnt_q, 8'h10);
        sleep = 1'b0;
        run_icyc(2);
        chk(cnt_q == 8'h11, "R10", "divider held in sleep", cnt_q, 8'h11);

        // R10: no wrap while sleeping at FF
        ps_bypass = 1'b1;
        sleep = 1'b1;
        write_cnt(8'hFF, 1'b1);
        run_icyc(5);
        chk(cnt_q == 8'hFF && !ovf_flag, "R10", "no wrap in sleep", {cnt_q, ovf_flag}, 9'h1FE);
        sleep = 1'b0;
        run_icyc(2);
        chk(cnt_q == 8'h01 && ovf_flag, "R10", "resume after sleep", {cnt_q, ovf_flag}, 9'h003);

        // R8: write on the increment edge wins, no flag
        write_cnt(8'hFF, 1'b1);
        align_to(3);
        cnt_wr_en   = 1'b1;
        cnt_wr_data = 8'h40;
        @(negedge clk);
        cnt_wr_en = 1'b0;
        chk(cnt_q == 8'h40, "R8", "write beats increment", cnt_q, 8'h40);
        chk(!ovf_flag, "R8", "no flag on write edge", ovf_flag, 0);

        // R6: clear on the wrap edge leaves the flag set
        write_cnt(8'hFF, 1'b1);
        run_icyc(1);
        chk(ovf_flag, "R6", "flag set before race", ovf_flag, 1);
        write_cnt(8'hFF, 1'b0);
        align_to(3);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(ovf_flag && cnt_q == 8'h00, "R6", "set beats clear", {cnt_q, ovf_flag}, 1);

        // R9: external edges, 1:1
        src_ext   = 1'b1;
        ps_bypass = 1'b1;
        write_cnt(8'h00, 1'b1);
        for (int p = 0; p < 3; p++) ext_pulse();
        chk(cnt_q == 8'h03, "R9", "three external edges", cnt_q, 3);
        run_icyc(10);
        chk(cnt_q == 8'h03, "R9", "internal ticks ignored", cnt_q, 3);
        // R9 with divider 1:2
        ps_bypass = 1'b0;
        ps_sel    = 3'd0;
        write_cnt(8'h00, 1'b1);
        for (int p = 0; p < 5; p++) ext_pulse();
        chk(cnt_q == 8'h02, "R9", "five edges at 1:2", cnt_q, 2);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                total++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule